// File: doc/BRIEF.md
# Significand Add, Normalize and Round Stage

This block finishes a binary floating-point addition or subtraction once the two operands have already been aligned to a common exponent. It receives the two extended significands, the exponent they share, the operand signs and a rounding-mode code. It forms the exact sum or difference and normalizes it with a leading-zero count. It then rounds to the target precision and packs a sign/exponent/fraction word, which it registers. The default parameters give IEEE 754 single precision: 8 exponent bits, 23 fraction bits and a 32-bit word.

For an effective subtraction, both orderings of the difference are formed by two parallel-prefix adders working side by side. The ordering that comes out nonnegative is the one kept, so no magnitude ever has to be complemented after the adder. The normalizer caps its left shift at the point where the exponent would fall below 1, which makes the result subnormal. The packing step lets a rounding carry move a subnormal into the normal range, or move the largest finite value to the overflow limit. NaN and infinity operands are handled elsewhere.

Input format. `sig_a` and `sig_b` carry, from the top bit down: the hidden bit, then the FRAC_W fraction bits, then GUARD_W guard bits. `sticky_b` is the OR of every bit of the aligned `sig_b` that fell below its lowest bit. `exp_big` is the biased exponent common to both aligned operands and lies in 1..2^EXP_W−2. A subnormal operand is presented with exponent 1 and a hidden bit of 0. `sign_b` is the sign that the second operand contributes once the requested operation has been applied, so `eff_sub` equals `sign_a ^ sign_b`. The value computed is therefore X = {sig_a,0} ± {sig_b,sticky_b}, scaled so that the hidden-bit position weighs 2^(exp_big−bias).

Top module: `fadd_norm_round`

## Requirements
- R1: `out_vld` and `result` reset to 0. `out_vld` is `in_vld` delayed by one clock, and `result` takes the value for the inputs of the previous cycle when `in_vld` was 1. Otherwise `result` holds its value.
- R2: When `eff_sub` is 0, the magnitude is the sum of the two extended significands and the sign is `sign_a`. A carry out of the sum shifts the significand right by one bit, raises the exponent by one, and ORs the bit shifted out into the sticky bit.
- R3: When `eff_sub` is 1, the magnitude is |{sig_a,0} − {sig_b,sticky_b}|. The sign is `sign_a` when the first operand is not smaller and `sign_b` otherwise. The result is never a NaN pattern, which is an all-ones exponent with a nonzero fraction.
- R4: A nonzero result whose leading one lies below the hidden-bit position is shifted left by its leading-zero count, and the exponent falls by the same amount.
- R5: The left shift never takes the exponent below 1. When the shift stops at that floor with the leading one still below the hidden position, the exponent field is 0, which is the subnormal encoding.
- R6: A subnormal result whose rounding increment carries into the hidden position comes out as a normal number with exponent field 1.
- R7: Mode code 0 rounds to nearest with ties to the even value, using the L, R and S bits, where S is the OR of every bit below R.
- R8: Mode code 4 rounds to nearest with ties away from zero.
- R9: Mode code 1 truncates toward zero.
- R10: Mode code 3 rounds toward +infinity and mode code 2 rounds toward −infinity. Each increments the magnitude only when R or S is set and the sign points in that direction.
- R11: A rounding increment that carries out of the significand leaves a fraction of 0 and raises the exponent by one.
- R12: An exponent reaching 2^EXP_W−1 gives infinity under codes 0 and 4, under code 3 for a positive sign and under code 2 for a negative sign. In every other case it gives the largest finite value with the result's sign.
- R13: An exact zero from a subtraction has sign 1 under code 2 and sign 0 under every other code. An exact zero from an addition keeps `sign_a`.
- R14: Mode codes 5, 6 and 7 behave exactly like code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Inputs on this cycle are to be processed |
| sig_a | input | FRAC_W+GUARD_W+1 | First aligned extended significand |
| sig_b | input | FRAC_W+GUARD_W+1 | Second aligned extended significand |
| sticky_b | input | 1 | OR of the bits shifted out of `sig_b` during alignment |
| exp_big | input | EXP_W | Common biased exponent of the aligned operands |
| eff_sub | input | 1 | 1 for effective subtraction, 0 for effective addition |
| sign_a | input | 1 | Sign of the first operand |
| sign_b | input | 1 | Effective sign contributed by the second operand |
| rnd_mode | input | 3 | Rounding-mode code (see R7 to R10 and R14) |
| out_vld | output | 1 | `result` holds a newly computed value |
| result | output | 1+EXP_W+FRAC_W | Packed sign, exponent field and fraction |

## Verification
The bench sweeps every pair of 6-bit extended significands on a small configuration with 4 exponent bits and 3 fraction bits. The sweep crosses both sticky values, both operations, all eight mode codes and exponents from the subnormal floor up to the overflow edge. Equal subtraction operands probe the zero-sign rule, which a wrong design would break by returning +0 under round-down. Exponent 1 with shallow differences probes the shift floor: an unlimited shifter would produce a bogus exponent, while a missing promotion path would leave a fraction bit stranded in the hidden position. Ties at every mode catch a swap of ties-to-even against ties-away. Exponent 14 with carries catches an overflow response that ignores sign and direction.

// File: rtl/fnr_pkg.sv
package fnr_pkg;

   typedef enum logic [2:0] {
      RM_NEAR_EVEN = 3'd0,
      RM_TO_ZERO   = 3'd1,
      RM_DOWN      = 3'd2,
      RM_UP        = 3'd3,
      RM_NEAR_AWAY = 3'd4
   } rmode_e;

   // decide whether the retained significand is bumped by one ulp
   function automatic logic fnr_round_inc(input logic [2:0] mode, input logic sgn,
                                          input logic lsb, input logic rbit, input logic sbit);
      logic inc;
      case (mode)
         RM_TO_ZERO:   inc = 1'b0;
         RM_DOWN:      inc = (rbit | sbit) & sgn;
         RM_UP:        inc = (rbit | sbit) & ~sgn;
         RM_NEAR_AWAY: inc = rbit;
         default:      inc = rbit & (lsb | sbit);
      endcase
      return inc;
   endfunction

   // on exponent overflow: 1 selects infinity, 0 the largest finite value
   function automatic logic fnr_ovf_inf(input logic [2:0] mode, input logic sgn);
      logic inf;
      case (mode)
         RM_TO_ZERO: inf = 1'b0;
         RM_DOWN:    inf = sgn;
         RM_UP:      inf = ~sgn;
         default:    inf = 1'b1;
      endcase
      return inf;
   endfunction

endpackage

// File: rtl/fnr_prefix_add.sv
module fnr_prefix_add #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout
);
   localparam int LV = (W > 1) ? $clog2(W) : 1;

   logic [W-1:0]        hp;
   logic [LV:0][W-1:0]  g;
   logic [LV:0][W-1:0]  p;
   logic                unused_p;

   assign hp = a ^ b;

   // Kogge-Stone carry tree; carry-in merged into bit 0 generate
   always_comb begin
      g[0] = a & b;
      g[0][0] = (a[0] & b[0]) | (hp[0] & cin);
      p[0] = hp;
      for (int lv = 0; lv < LV; lv++) begin
         for (int i = 0; i < W; i++) begin
            if (i >= (1 << lv)) begin
               g[lv+1][i] = g[lv][i] | (p[lv][i] & g[lv][i - (1 << lv)]);
               p[lv+1][i] = p[lv][i] & p[lv][i - (1 << lv)];
            end else begin
               g[lv+1][i] = g[lv][i];
               p[lv+1][i] = p[lv][i];
            end
         end
      end
   end

   generate
      for (genvar i = 0; i < W; i++) begin : g_sum
         if (i == 0) begin : g_lsb
            assign sum[i] = hp[i] ^ cin;
         end else begin : g_upper
            assign sum[i] = hp[i] ^ g[LV][i-1];
         end
      end
   endgenerate

   assign cout     = g[LV][W-1];
   assign unused_p = ^p[LV];

endmodule

// File: rtl/fnr_dual_diff.sv
module fnr_dual_diff #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         eff_sub,
   output logic [W:0]   mag,
   output logic         pick_b,
   output logic         c_ab,
   output logic         c_ba
);
   logic [W-1:0] b_op;
   logic [W-1:0] s_ab;
   logic [W-1:0] s_ba;

   assign b_op = eff_sub ? ~b : b;

   // a + b, or a - b when subtracting
   fnr_prefix_add #(.W(W)) u_ab (
      .a(a), .b(b_op), .cin(eff_sub), .sum(s_ab), .cout(c_ab)
   );

   // b - a, always formed in parallel
   fnr_prefix_add #(.W(W)) u_ba (
      .a(b), .b(~a), .cin(1'b1), .sum(s_ba), .cout(c_ba)
   );

   always_comb begin
      if (!eff_sub) begin
         mag    = {c_ab, s_ab};
         pick_b = 1'b0;
      end else if (c_ab) begin
         mag    = {1'b0, s_ab};
         pick_b = 1'b0;
      end else begin
         mag    = {1'b0, s_ba};
         pick_b = 1'b1;
      end
   end

endmodule

// File: rtl/fnr_normalize.sv
module fnr_normalize #(
   parameter int XW    = 27,
   parameter int EXP_W = 8
) (
   input  logic [XW:0]    mag,
   input  logic [EXP_W-1:0] exp_in,
   output logic [XW-1:0]  nsig,
   output logic           fold,
   output logic [EXP_W:0] field,
   output logic           uflow
);
   localparam int CW  = $clog2(XW + 1);
   localparam int SHW = ((CW > EXP_W) ? CW : EXP_W) + 1;

   logic [SHW-1:0]  lzc;
   logic [SHW-1:0]  lim;
   logic [SHW-1:0]  sh;
   logic [EXP_W:0]  e_eff;
   logic            carry;

   assign carry = mag[XW];

   // leading-zero count of the non-carry part
   always_comb begin
      lzc = SHW'(XW);
      for (int i = 0; i < XW; i++) begin
         if (mag[i]) lzc = SHW'(XW - 1 - i);
      end
   end

   // shift is capped so the exponent stops at 1
   assign lim   = SHW'(exp_in) - SHW'(1);
   assign uflow = !carry && (lzc > lim);
   assign sh    = uflow ? lim : lzc;

   always_comb begin
      if (carry) begin
         nsig  = mag[XW:1];
         fold  = mag[0];
         e_eff = {1'b0, exp_in} + (EXP_W+1)'(1);
      end else begin
         nsig  = mag[XW-1:0] << sh;
         fold  = 1'b0;
         e_eff = {1'b0, exp_in} - (EXP_W+1)'(sh);
      end
   end

   assign field = uflow ? '0 : e_eff;

endmodule

// File: rtl/fnr_round_pack.sv
module fnr_round_pack
   import fnr_pkg::*;
#(
   parameter int EXP_W   = 8,
   parameter int FRAC_W  = 23,
   parameter int GUARD_W = 2
) (
   input  logic [FRAC_W+GUARD_W:0]  nbody,
   input  logic                     fold,
   input  logic [EXP_W:0]           field,
   input  logic                     sgn,
   input  logic [2:0]               mode,
   output logic [EXP_W+FRAC_W:0]    res
);
   localparam int              WW   = EXP_W + 1 + FRAC_W;
   localparam logic [EXP_W:0]  EMAX = (EXP_W+1)'((1 << EXP_W) - 1);

   logic            lbit, rbit, sbit, inc, ovf;
   logic [WW-1:0]   wide;
   logic [EXP_W:0]  wexp;

   assign lbit = nbody[GUARD_W+1];
   assign rbit = nbody[GUARD_W];
   assign sbit = (|nbody[GUARD_W-1:0]) | fold;
   assign inc  = fnr_round_inc(mode, sgn, lbit, rbit, sbit);

   // increment carries into the exponent field: covers both ulp overflow
   // and promotion of a subnormal into the normal range
   assign wide = {field, nbody[FRAC_W+GUARD_W:GUARD_W+1]} + WW'(inc);
   assign wexp = wide[WW-1:FRAC_W];
   assign ovf  = (wexp >= EMAX);

   always_comb begin
      if (!ovf) begin
         res = {sgn, wide[EXP_W+FRAC_W-1:0]};
      end else if (fnr_ovf_inf(mode, sgn)) begin
         res = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      end else begin
         res = {sgn, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
      end
   end

endmodule

// File: rtl/fadd_norm_round.sv
module fadd_norm_round
   import fnr_pkg::*;
#(
   parameter int EXP_W   = 8,
   parameter int FRAC_W  = 23,
   parameter int GUARD_W = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_vld,
   input  logic [FRAC_W+GUARD_W:0]   sig_a,
   input  logic [FRAC_W+GUARD_W:0]   sig_b,
   input  logic                      sticky_b,
   input  logic [EXP_W-1:0]          exp_big,
   input  logic                      eff_sub,
   input  logic                      sign_a,
   input  logic                      sign_b,
   input  logic [2:0]                rnd_mode,
   output logic                      out_vld,
   output logic [EXP_W+FRAC_W:0]     result
);
   localparam int SIG_W  = FRAC_W + GUARD_W + 1;
   localparam int XW     = SIG_W + 1;
   localparam int WORD_W = 1 + EXP_W + FRAC_W;

   generate
      if (GUARD_W < 2) begin : g_bad_guard
         $error("fadd_norm_round: GUARD_W must be at least 2");
      end
      if (EXP_W < 3) begin : g_bad_exp
         $error("fadd_norm_round: EXP_W must be at least 3");
      end
      if (FRAC_W < 1) begin : g_bad_frac
         $error("fadd_norm_round: FRAC_W must be at least 1");
      end
   endgenerate

   logic [XW-1:0]     xa, xb;
   logic [XW:0]       mag;
   logic              pick_b, c_ab, c_ba;
   logic              is_zero, sgn_r;
   logic [XW-1:0]     nsig;
   logic              fold, uflow;
   logic [EXP_W:0]    field;
   logic [WORD_W-1:0] rnd_res;
   logic [WORD_W-1:0] res_c;

   // sticky becomes one more fractional bit of the second operand
   assign xa = {sig_a, 1'b0};
   assign xb = {sig_b, sticky_b};

   fnr_dual_diff #(.W(XW)) u_diff (
      .a(xa), .b(xb), .eff_sub(eff_sub),
      .mag(mag), .pick_b(pick_b), .c_ab(c_ab), .c_ba(c_ba)
   );

   assign is_zero = (mag == '0);

   always_comb begin
      if (is_zero) sgn_r = eff_sub ? (rnd_mode == RM_DOWN) : sign_a;
      else         sgn_r = pick_b ? sign_b : sign_a;
   end

   fnr_normalize #(.XW(XW), .EXP_W(EXP_W)) u_norm (
      .mag(mag), .exp_in(exp_big),
      .nsig(nsig), .fold(fold), .field(field), .uflow(uflow)
   );

   fnr_round_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .GUARD_W(GUARD_W)) u_rnd (
      .nbody(nsig[XW-2:0]), .fold(fold), .field(field),
      .sgn(sgn_r), .mode(rnd_mode), .res(rnd_res)
   );

   assign res_c = is_zero ? {sgn_r, {(WORD_W-1){1'b0}}} : rnd_res;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
         result  <= '0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) result <= res_c;
      end
   end

endmodule

// File: rtl/fadd_norm_round_chk.sv
module fadd_norm_round_chk
   import fnr_pkg::*;
#(
   parameter int EXP_W   = 8,
   parameter int FRAC_W  = 23,
   parameter int GUARD_W = 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_vld,
   input logic [FRAC_W+GUARD_W:0] sig_a,
   input logic [FRAC_W+GUARD_W:0] sig_b,
   input logic                    sticky_b,
   input logic                    eff_sub,
   input logic                    sign_a,
   input logic [2:0]              rnd_mode,
   input logic                    out_vld,
   input logic [EXP_W+FRAC_W:0]   result,
   input logic                    c_ab,
   input logic                    c_ba,
   input logic                    uflow,
   input logic                    nsig_top,
   input logic                    is_zero
);
   localparam int WORD_W = 1 + EXP_W + FRAC_W;

   // R1
   vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_vld);

   // R1
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> (!out_vld && $stable(result)));

   // R3
   order_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eff_sub |-> (c_ab || c_ba));

   // R5
   floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !is_zero |-> (uflow == !nsig_top));

   // R3
   no_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> !((&result[WORD_W-2:FRAC_W]) && (|result[FRAC_W-1:0])));

   // R2
   add_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && !eff_sub) |=> (result[WORD_W-1] == $past(sign_a)));

   // R13
   zero_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && eff_sub && ({sig_a, 1'b0} == {sig_b, sticky_b}))
      |=> (result == {($past(rnd_mode) == RM_DOWN), {(WORD_W-1){1'b0}}}));

   // R9
   rz_finite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && rnd_mode == RM_TO_ZERO) |=> !(&result[WORD_W-2:FRAC_W]));

endmodule

bind fadd_norm_round fadd_norm_round_chk #(
   .EXP_W(EXP_W), .FRAC_W(FRAC_W), .GUARD_W(GUARD_W)
) u_fadd_norm_round_chk (
   .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
   .sig_a(sig_a), .sig_b(sig_b), .sticky_b(sticky_b),
   .eff_sub(eff_sub), .sign_a(sign_a), .rnd_mode(rnd_mode),
   .out_vld(out_vld), .result(result),
   .c_ab(c_ab), .c_ba(c_ba), .uflow(uflow),
   .nsig_top(nsig[XW-1]), .is_zero(is_zero)
);

// File: tb/test_fadd_norm_round.sv
`timescale 1ns/1ps
module test_fadd_norm_round;
   localparam int EXP_W   = 4;
   localparam int FRAC_W  = 3;
   localparam int GUARD_W = 2;
   localparam int SIG_W   = FRAC_W + GUARD_W + 1;
   localparam int WORD_W  = 1 + EXP_W + FRAC_W;
   localparam int P_H     = SIG_W;             // hidden-bit position in {sig,extra}
   localparam int EMAX    = (1 << EXP_W) - 1;
   localparam int NVEC    = 1 << (2*SIG_W + 5);

   logic                clk = 1'b0;
   logic                rst_n;
   logic                in_vld;
   logic [SIG_W-1:0]    sig_a, sig_b;
   logic                sticky_b;
   logic [EXP_W-1:0]    exp_big;
   logic                eff_sub, sign_a, sign_b;
   logic [2:0]          rnd_mode;
   logic                out_vld;
   logic [WORD_W-1:0]   result;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   fadd_norm_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .GUARD_W(GUARD_W)) i_fadd_norm_round (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
      .sig_a(sig_a), .sig_b(sig_b), .sticky_b(sticky_b), .exp_big(exp_big),
      .eff_sub(eff_sub), .sign_a(sign_a), .sign_b(sign_b), .rnd_mode(rnd_mode),
      .out_vld(out_vld), .result(result)
   );

   // exact arithmetic reference: X = A' +/- B', rounded from the integer
   task automatic ref_calc(input int a, input int b, input int st, input int sub,
                           input int sa, input int sb, input int e, input int mode,
                           output logic [WORD_W-1:0] res, output string tag);
      int av, bv, r, sgn, m, mp, be, u, q, half, rest, inc, field, pre_sub, rcarry, toinf;
      av = a * 2;
      bv = b * 2 + st;
      m  = (mode > 4) ? 0 : mode;
      if (sub != 0) begin
         r   = (av >= bv) ? av - bv : bv - av;
         sgn = (av >= bv) ? sa : sb;
      end else begin
         r   = av + bv;
         sgn = sa;
      end
      if (r == 0) begin
         sgn = (sub != 0) ? ((m == 2) ? 1 : 0) : sa;
         res = {sgn[0], {(WORD_W-1){1'b0}}};
         tag = (mode > 4) ? "R14" : "R13";
         return;
      end
      mp = 0;
      for (int k = 0; k < 16; k++) if (((r >> k) & 1) != 0) mp = k;
      be = e + mp - P_H;
      if (be < 1) be = 1;
      u = be - e + P_H - FRAC_W;
      if (u > 0) begin
         q    = r >> u;
         half = (r >> (u - 1)) & 1;
         rest = ((r & ((1 << (u - 1)) - 1)) != 0) ? 1 : 0;
      end else begin
         q    = r << (-u);
         half = 0;
         rest = 0;
      end
      pre_sub = (q < (1 << FRAC_W)) ? 1 : 0;
      case (m)
         1: inc = 0;
         2: inc = ((half | rest) != 0 && sgn != 0) ? 1 : 0;
         3: inc = ((half | rest) != 0 && sgn == 0) ? 1 : 0;
         4: inc = half;
         default: inc = (half != 0 && (rest != 0 || (q & 1) != 0)) ? 1 : 0;
      endcase
      q = q + inc;
      rcarry = 0;
      if (q >= (1 << (FRAC_W + 1))) begin
         q = q >> 1;
         be = be + 1;
         rcarry = 1;
      end
      field = (q >= (1 << FRAC_W)) ? be : 0;
      if (field >= EMAX) begin
         toinf = (m == 0 || m == 4 || (m == 3 && sgn == 0) || (m == 2 && sgn != 0)) ? 1 : 0;
         if (toinf != 0) res = {sgn[0], {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
         else            res = {sgn[0], {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
         tag = "R12";
      end else begin
         res = {sgn[0], field[EXP_W-1:0], q[FRAC_W-1:0]};
         if (rcarry != 0)                          tag = "R11";
         else if (pre_sub != 0 && field != 0)      tag = "R6";
         else if (field == 0)                      tag = "R5";
         else if ((half | rest) != 0) begin
            case (m)
               1: tag = "R9";
               2, 3: tag = "R10";
               4: tag = "R8";
               default: tag = "R7";
            endcase
         end else if (sub == 0)                    tag = "R2";
         else if (mp < P_H)                        tag = "R4";
         else                                      tag = "R3";
      end
      if (mode > 4) tag = "R14";
   endtask

   task automatic check(input string tag, input logic [WORD_W-1:0] act,
                        input logic [WORD_W-1:0] expv, input int vec);
      checks++;
      if (act !== expv) begin
         fails++;
         if (fails <= 20)
            $display("FAIL %s vec=%0d actual=%h expected=%h", tag, vec, act, expv);
      end
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : main
      logic [WORD_W-1:0] exp_prev;
      string             tag_prev;
      int                have_prev;
      int                esel [8] = '{1, 2, 3, 4, 7, 12, 13, 14};

      rst_n = 1'b0; in_vld = 1'b0; sig_a = '0; sig_b = '0; sticky_b = 1'b0;
      exp_big = 4'd1; eff_sub = 1'b0; sign_a = 1'b0; sign_b = 1'b0; rnd_mode = 3'd0;
      have_prev = 0; exp_prev = '0; tag_prev = "";
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", {out_vld, result}, '0, -1);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         logic [WORD_W-1:0] ev;
         string             tg;
         int                a, b, st, sub, mode, e, sa, sb;
         @(negedge clk);
         if (have_prev != 0) begin
            check("R1", {7'b0, out_vld}, {7'b0, 1'b1}, i - 1);
            check(tag_prev, result, exp_prev, i - 1);
         end
         a    = i & 63;
         b    = (i >> 6) & 63;
         st   = (i >> 12) & 1;
         sub  = (i >> 13) & 1;
         mode = (i >> 14) & 7;
         e    = esel[((i >> 2) ^ (i >> 9)) & 7];
         sa   = (i ^ (i >> 7)) & 1;
         sb   = (sub != 0) ? 1 - sa : sa;
         sig_a = SIG_W'(a); sig_b = SIG_W'(b); sticky_b = st[0];
         eff_sub = sub[0]; rnd_mode = mode[2:0]; exp_big = EXP_W'(e);
         sign_a = sa[0]; sign_b = sb[0]; in_vld = 1'b1;
         ref_calc(a, b, st, sub, sa, sb, e, mode, ev, tg);
         exp_prev = ev; tag_prev = tg; have_prev = 1;
      end
      @(negedge clk);
      check(tag_prev, result, exp_prev, NVEC - 1);
      // R1: idle input leaves result unchanged and drops out_vld
      in_vld = 1'b0;
      sig_a = '1; sig_b = '0; eff_sub = 1'b0;
      @(negedge clk);
      check("R1", {7'b0, out_vld}, '0, -2);
      check("R1", result, exp_prev, -2);
      @(negedge clk);
      check("R1", result, exp_prev, -3);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule